// File: doc/BRIEF.md
# Packed Lane Integer Arithmetic Unit

This block computes one lane of a packed-vector integer datapath. Each cycle it can accept two lane operands and an operation code. One registered clock later it returns the lane result together with a valid flag. The supported operations are:

- add and subtract, either wrapping or saturating
- negate and absolute value, both wrapping
- saturating absolute value
- floor and round-half-up averages
- minimum and maximum, with signed and unsigned forms as separate operations

A wide vector unit places one instance per lane and drives every lane from a common opcode.

The lane width is the parameter `LANE_W`, with a default of 16. Widths of 8 or 32 are equally valid. In the text below, W stands for `LANE_W`, and hexadecimal examples assume W = 16. The opcode is 4 bits wide. A result register loads only when a request is present, so it holds its last value while the lane is idle.

Top module: `lane_alu_top`

## Requirements
- R1: Opcode 0 returns (A + B) mod 2^W and opcode 1 returns (A − B) mod 2^W; for example 0xFFFF + 0x0002 gives 0x0001.
- R2: Opcodes 2 (saturating add) and 3 (saturating subtract) work as follows.
  - Both operands are sign-extended and combined into a W+1-bit sum.
  - The sum has overflowed when its top two bits differ.
  - On overflow the result clamps to the largest positive value (0x7FFF) for a positive sum and to the most negative value (0x8000) for a negative sum. Examples: 0x7000 + 0x2000 gives 0x7FFF, 0x8000 + 0x8000 gives 0x8000, and 0x8000 − 0x0001 gives 0x8000.
  - Without overflow the result is the exact signed sum or difference.
- R3: Opcode 4 returns the wrapping negation of A, and opcode 5 returns the wrapping absolute value of A. Operand B is unused by both. Examples: neg(0x0001) = 0xFFFF, abs(0xFFFF) = 0x0001 and abs(0x8000) = 0x8000.
- R4: Opcode 6 returns the saturating absolute value of A: negative inputs take the saturating negate path, so 0x8000 gives 0x7FFF, and the result is never negative.
- R5: Opcode 7 returns floor((A + B) / 2) and opcode 8 returns (A + B) / 2 rounded half up. Both treat the operands as signed and compute the sum at full precision, so they never overflow. For example, avg(3, 6) = 4 and the rounded form gives 5.
- R6: Opcodes 9 and 10 are signed minimum and maximum, for example min(0x8000, 0x0001) = 0x8000. Equal operands return B for the minimum.
- R7: Opcodes 11 and 12 are unsigned minimum and maximum, for example min(0x8000, 0x0001) = 0x0001.
- R8: Opcodes 13, 14 and 15 are reserved and return 0.
- R9: The result register loads only in a cycle where `in_valid` is 1. Otherwise it keeps its value, whatever the opcode and operands are.
- R10: `out_valid` equals the `in_valid` of the previous cycle. A synchronous reset clears both `out_valid` and `out_result` to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | A request is present this cycle |
| in_op | input | 4 | Operation code (see R1 to R8) |
| in_a | input | LANE_W | Operand A |
| in_b | input | LANE_W | Operand B |
| out_valid | output | 1 | `out_result` holds the result of last cycle's request |
| out_result | output | LANE_W | Registered lane result |

## Verification
The cases hardest to reach from the ports are the exact saturation boundaries and the single self-overflowing input, 0x8000. They matter most for negate and saturating absolute value. Random operands almost never land a sum exactly one past the representable range, and random inputs almost never hit the most negative value.

The stimulus therefore sweeps every opcode across the full cross product of a list of corner values: 0, ±1, the two range extremes and their neighbours, and the example operands named in the requirements. A long pseudo-random stream follows, to cover the interior.

Expected results come from plain integer arithmetic in the bench, using explicit range clamps rather than the bit comparison the design uses. Idle gaps and a mid-run reset are interleaved with the requests to show the hold and clear behaviour.

// File: rtl/lane_alu_pkg.sv
package lane_alu_pkg;

    localparam int OP_W = 4;

    typedef enum logic [OP_W-1:0] {
        OP_ADD  = 4'd0,
        OP_SUB  = 4'd1,
        OP_ADDS = 4'd2,
        OP_SUBS = 4'd3,
        OP_NEG  = 4'd4,
        OP_ABS  = 4'd5,
        OP_ABSS = 4'd6,
        OP_AVG  = 4'd7,
        OP_AVGR = 4'd8,
        OP_MIN  = 4'd9,
        OP_MAX  = 4'd10,
        OP_MINU = 4'd11,
        OP_MAXU = 4'd12
    } lane_op_e;

    // Controls for the shared adder/subtractor.
    typedef struct packed {
        logic unary;     // compute 0 - A instead of A op B
        logic subtract;
        logic saturate;
    } adder_ctl_t;

    // Which result path feeds the output register.
    typedef enum logic [2:0] {
        SRC_ADDER,
        SRC_ABS,
        SRC_AVG,
        SRC_MINMAX_S,
        SRC_MINMAX_U,
        SRC_ZERO
    } result_src_e;

    typedef struct packed {
        adder_ctl_t  add;
        result_src_e src;
        logic        pick_hi;   // average: rounded form; min/max: maximum
    } op_decode_t;

    function automatic op_decode_t decode_op(input logic [OP_W-1:0] op);
        op_decode_t d;
        d = '{add: '{unary: 1'b0, subtract: 1'b0, saturate: 1'b0},
              src: SRC_ZERO, pick_hi: 1'b0};
        case (op)
            OP_ADD:  begin d.src = SRC_ADDER; end
            OP_SUB:  begin d.src = SRC_ADDER; d.add.subtract = 1'b1; end
            OP_ADDS: begin d.src = SRC_ADDER; d.add.saturate = 1'b1; end
            OP_SUBS: begin d.src = SRC_ADDER; d.add.subtract = 1'b1; d.add.saturate = 1'b1; end
            OP_NEG:  begin d.src = SRC_ADDER; d.add.unary = 1'b1; d.add.subtract = 1'b1; end
            OP_ABS:  begin d.src = SRC_ABS;   d.add.unary = 1'b1; d.add.subtract = 1'b1; end
            OP_ABSS: begin d.src = SRC_ABS;   d.add.unary = 1'b1; d.add.subtract = 1'b1;
                           d.add.saturate = 1'b1; end
            OP_AVG:  begin d.src = SRC_AVG; end
            OP_AVGR: begin d.src = SRC_AVG; d.pick_hi = 1'b1; end
            OP_MIN:  begin d.src = SRC_MINMAX_S; end
            OP_MAX:  begin d.src = SRC_MINMAX_S; d.pick_hi = 1'b1; end
            OP_MINU: begin d.src = SRC_MINMAX_U; end
            OP_MAXU: begin d.src = SRC_MINMAX_U; d.pick_hi = 1'b1; end
            default: begin d.src = SRC_ZERO; end
        endcase
        return d;
    endfunction

endpackage

// File: rtl/lane_alu_addsub.sv
// Shared add/subtract with optional saturation on a (W+1)-bit signed sum.
module lane_alu_addsub #(
    parameter int LANE_W = 16
) (
    input  logic [LANE_W-1:0] x,
    input  logic [LANE_W-1:0] y,
    input  logic              subtract,
    input  logic              saturate,
    output logic [LANE_W-1:0] res,
    output logic              ovf
);
    localparam int EXT_W = LANE_W + 1;
    localparam logic [LANE_W-1:0] POS_LIMIT = {1'b0, {(LANE_W-1){1'b1}}};
    localparam logic [LANE_W-1:0] NEG_LIMIT = {1'b1, {(LANE_W-1){1'b0}}};

    logic [EXT_W-1:0] xs, ys, sum;

    always_comb begin
        xs  = {x[LANE_W-1], x};
        ys  = {y[LANE_W-1], y};
        sum = subtract ? (xs - ys) : (xs + ys);
        // Top two bits of the extended sum disagree: out of lane range.
        ovf = sum[EXT_W-1] ^ sum[EXT_W-2];
        if (saturate && ovf)
            res = sum[EXT_W-1] ? NEG_LIMIT : POS_LIMIT;
        else
            res = sum[LANE_W-1:0];
    end
endmodule

// File: rtl/lane_alu_avg.sv
// Signed floor and round-half-up average on a full-precision sum.
module lane_alu_avg #(
    parameter int LANE_W = 16
) (
    input  logic [LANE_W-1:0] x,
    input  logic [LANE_W-1:0] y,
    output logic [LANE_W-1:0] avg_floor,
    output logic [LANE_W-1:0] avg_round
);
    localparam int SUM_W = LANE_W + 2;

    logic [SUM_W-1:0] sum, sum_up;

    always_comb begin
        sum       = {{2{x[LANE_W-1]}}, x} + {{2{y[LANE_W-1]}}, y};
        sum_up    = sum + {{(SUM_W-1){1'b0}}, 1'b1};
        avg_floor = sum[LANE_W:1];
        avg_round = sum_up[LANE_W:1];
    end
endmodule

// File: rtl/lane_alu_minmax.sv
// Minimum/maximum; SIGNED_CMP selects the biased-key (signed) comparator.
module lane_alu_minmax #(
    parameter int LANE_W     = 16,
    parameter bit SIGNED_CMP = 1'b1
) (
    input  logic [LANE_W-1:0] x,
    input  logic [LANE_W-1:0] y,
    output logic [LANE_W-1:0] lo,
    output logic [LANE_W-1:0] hi
);
    logic [LANE_W-1:0] kx, ky;

    generate
        if (SIGNED_CMP) begin : g_signed_key
            // Flipping the sign bit maps signed order onto unsigned order.
            assign kx = {~x[LANE_W-1], x[LANE_W-2:0]};
            assign ky = {~y[LANE_W-1], y[LANE_W-2:0]};
        end else begin : g_plain_key
            assign kx = x;
            assign ky = y;
        end
    endgenerate

    logic x_not_below;
    assign x_not_below = (kx >= ky);
    assign lo = x_not_below ? y : x;   // equal keys: minimum takes y
    assign hi = x_not_below ? x : y;
endmodule

// File: rtl/lane_alu_top.sv
module lane_alu_top
    import lane_alu_pkg::*;
#(
    parameter int LANE_W = 16
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  in_valid,
    input  logic [OP_W-1:0]       in_op,
    input  logic [LANE_W-1:0]     in_a,
    input  logic [LANE_W-1:0]     in_b,
    output logic                  out_valid,
    output logic [LANE_W-1:0]     out_result
);
    op_decode_t dec;
    assign dec = decode_op(in_op);

    // Shared adder: negate/abs forms compute 0 - A.
    logic [LANE_W-1:0] add_x, add_y, add_res;
    logic              add_ovf;
    assign add_x = dec.add.unary ? '0   : in_a;
    assign add_y = dec.add.unary ? in_a : in_b;

    lane_alu_addsub #(.LANE_W(LANE_W)) addsub_i (
        .x(add_x), .y(add_y),
        .subtract(dec.add.subtract), .saturate(dec.add.saturate),
        .res(add_res), .ovf(add_ovf)
    );

    logic [LANE_W-1:0] abs_res;
    assign abs_res = in_a[LANE_W-1] ? add_res : in_a;

    logic [LANE_W-1:0] avg_fl, avg_rd;
    lane_alu_avg #(.LANE_W(LANE_W)) avg_i (
        .x(in_a), .y(in_b), .avg_floor(avg_fl), .avg_round(avg_rd)
    );

    logic [LANE_W-1:0] s_lo, s_hi, u_lo, u_hi;
    lane_alu_minmax #(.LANE_W(LANE_W), .SIGNED_CMP(1'b1)) mm_signed_i (
        .x(in_a), .y(in_b), .lo(s_lo), .hi(s_hi)
    );
    lane_alu_minmax #(.LANE_W(LANE_W), .SIGNED_CMP(1'b0)) mm_unsigned_i (
        .x(in_a), .y(in_b), .lo(u_lo), .hi(u_hi)
    );

    logic [LANE_W-1:0] next_result;
    always_comb begin
        case (dec.src)
            SRC_ADDER:    next_result = add_res;
            SRC_ABS:      next_result = abs_res;
            SRC_AVG:      next_result = dec.pick_hi ? avg_rd : avg_fl;
            SRC_MINMAX_S: next_result = dec.pick_hi ? s_hi : s_lo;
            SRC_MINMAX_U: next_result = dec.pick_hi ? u_hi : u_lo;
            default:      next_result = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid  <= 1'b0;
            out_result <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid)
                out_result <= next_result;
        end
    end

    // ---------------- assertions ----------------
    // R10
    p_valid_follow_r10: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);
    p_valid_drop_r10: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);
    // R9
    p_hold_idle_r9: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(out_result));
    // R2: two non-negative operands never saturate into a negative result
    p_sat_pos_r2: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_op == OP_ADDS && !in_a[LANE_W-1] && !in_b[LANE_W-1])
        |=> !out_result[LANE_W-1]);
    // R4
    p_abss_nonneg_r4: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_op == OP_ABSS) |=> !out_result[LANE_W-1]);
    // R6
    p_smin_pick_r6: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_op == OP_MIN)
        |=> (out_result == $past(in_a) || out_result == $past(in_b)));
    // R7
    p_umin_bound_r7: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_op == OP_MINU)
        |=> (out_result <= $past(in_a) && out_result <= $past(in_b)));
    // R8
    p_reserved_zero_r8: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_op > OP_MAXU) |=> (out_result == '0));

endmodule

// File: tb/lane_alu_top_tb_top.sv
module lane_alu_top_tb_top;
    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst;
    logic         in_valid;
    logic [3:0]   in_op;
    logic [W-1:0] in_a, in_b;
    logic         out_valid;
    logic [W-1:0] out_result;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;
    logic [W-1:0] last_exp;

    always #5 clk = ~clk;

    lane_alu_top #(.LANE_W(W)) dut_i (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_op(in_op),
        .in_a(in_a), .in_b(in_b), .out_valid(out_valid), .out_result(out_result)
    );

    function automatic int clamp16(input int v);
        if (v > 32767)  return 32767;
        if (v < -32768) return -32768;
        return v;
    endfunction

    function automatic logic [W-1:0] model(input logic [3:0] op,
                                           input logic [W-1:0] a,
                                           input logic [W-1:0] b);
        int sa, sb, ua, ub, r;
        sa = int'($signed(a)); sb = int'($signed(b));
        ua = int'(a);          ub = int'(b);
        case (op)
            4'd0:  r = ua + ub;
            4'd1:  r = ua - ub;
            4'd2:  r = clamp16(sa + sb);
            4'd3:  r = clamp16(sa - sb);
            4'd4:  r = -sa;
            4'd5:  r = (sa < 0) ? -sa : sa;
            4'd6:  r = clamp16((sa < 0) ? -sa : sa);
            4'd7:  r = (sa + sb) >>> 1;
            4'd8:  r = (sa + sb + 1) >>> 1;
            4'd9:  r = (sa < sb) ? sa : sb;
            4'd10: r = (sa > sb) ? sa : sb;
            4'd11: r = (ua < ub) ? ua : ub;
            4'd12: r = (ua > ub) ? ua : ub;
            default: r = 0;
        endcase
        return r[W-1:0];
    endfunction

    function automatic string req_of(input logic [3:0] op);
        case (op)
            4'd0, 4'd1:  return "R1";
            4'd2, 4'd3:  return "R2";
            4'd4, 4'd5:  return "R3";
            4'd6:        return "R4";
            4'd7, 4'd8:  return "R5";
            4'd9, 4'd10: return "R6";
            4'd11, 4'd12: return "R7";
            default:     return "R8";
        endcase
    endfunction

    task automatic check(input string req, input logic [W-1:0] act,
                         input logic [W-1:0] exp, input string what);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Called at a negedge; returns at the next negedge with the result checked.
    task automatic do_op(input logic [3:0] op, input logic [W-1:0] a,
                         input logic [W-1:0] b, input logic [W-1:0] exp);
        in_valid = 1'b1; in_op = op; in_a = a; in_b = b;
        @(negedge clk);
        check("R10", {15'd0, out_valid}, 16'd1, "valid after request");
        check(req_of(op), out_result, exp,
              $sformatf("op=%0d a=%h b=%h", op, a, b));
        last_exp = exp;
    endtask

    logic [W-1:0] corners [16] = '{16'h0000, 16'h0001, 16'h0002, 16'h0003,
                                   16'h0006, 16'h2000, 16'h4000, 16'h7000,
                                   16'h7FFE, 16'h7FFF, 16'h8000, 16'h8001,
                                   16'hC000, 16'hFFFD, 16'hFFFE, 16'hFFFF};

    initial begin
        logic [31:0] lfsr;
        rst = 1'b1; in_valid = 1'b0; in_op = '0; in_a = '0; in_b = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R10: reset state
        check("R10", {15'd0, out_valid}, 16'd0, "out_valid after reset");
        check("R10", out_result, 16'd0, "out_result after reset");

        // Directed examples from the requirements
        do_op(4'd0,  16'hFFFF, 16'h0002, 16'h0001); // R1
        do_op(4'd2,  16'h7000, 16'h2000, 16'h7FFF); // R2
        do_op(4'd2,  16'h8000, 16'h8000, 16'h8000); // R2
        do_op(4'd3,  16'h8000, 16'h0001, 16'h8000); // R2
        do_op(4'd4,  16'h0001, 16'h1234, 16'hFFFF); // R3
        do_op(4'd5,  16'h8000, 16'h0000, 16'h8000); // R3
        do_op(4'd5,  16'hFFFF, 16'h7777, 16'h0001); // R3
        do_op(4'd6,  16'h8000, 16'h0000, 16'h7FFF); // R4
        do_op(4'd7,  16'h0003, 16'h0006, 16'h0004); // R5
        do_op(4'd8,  16'h0003, 16'h0006, 16'h0005); // R5
        do_op(4'd7,  16'h7FFF, 16'h7FFF, 16'h7FFF); // R5 no overflow
        do_op(4'd9,  16'h8000, 16'h0001, 16'h8000); // R6
        do_op(4'd10, 16'h8000, 16'h0001, 16'h0001); // R6
        do_op(4'd11, 16'h8000, 16'h0001, 16'h0001); // R7
        do_op(4'd15, 16'h1234, 16'h5678, 16'h0000); // R8

        // R9: idle cycles hold the result regardless of inputs
        in_valid = 1'b0; in_op = 4'd0; in_a = 16'h1111; in_b = 16'h2222;
        @(negedge clk);
        check("R10", {15'd0, out_valid}, 16'd0, "valid drops when idle");
        check("R9", out_result, last_exp, "hold while idle");
        in_op = 4'd6; in_a = 16'h8000;
        @(negedge clk);
        check("R9", out_result, last_exp, "hold while idle, op changed");

        // Corner sweep: every opcode over all corner pairs
        for (int op = 0; op < 16; op++)
            for (int i = 0; i < 16; i++)
                for (int j = 0; j < 16; j++)
                    do_op(op[3:0], corners[i], corners[j],
                          model(op[3:0], corners[i], corners[j]));

        // Mid-run reset clears state (R10)
        rst = 1'b1; in_valid = 1'b1; in_op = 4'd0; in_a = 16'h0005; in_b = 16'h0005;
        @(negedge clk);
        check("R10", {15'd0, out_valid}, 16'd0, "out_valid during reset");
        check("R10", out_result, 16'd0, "out_result during reset");
        rst = 1'b0; in_valid = 1'b0;
        @(negedge clk);

        // Pseudo-random interior
        lfsr = 32'hACE1_1357;
        for (int k = 0; k < 4000; k++) begin
            logic [3:0]   rop;
            logic [W-1:0] ra, rb;
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            rop = lfsr[3:0];
            ra  = lfsr[19:4];
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            rb  = lfsr[27:12];
            do_op(rop, ra, rb, model(rop, ra, rb));
            if (k % 97 == 0) begin
                in_valid = 1'b0; in_a = ~ra; in_b = ~rb;
                @(negedge clk);
                check("R9", out_result, last_exp, "hold in random gap");
            end
        end

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL R10 watchdog: actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end
endmodule